// File: doc/BRIEF.md
# Receive Character Queue with Per-Entry Status

This block is a small first-in first-out queue placed between the deserializer of an asynchronous serial receiver and the host's read port. Each completed character is written in together with its status: a frame-error bit derived from the stop-bit check, a parity-error bit, a ninth data bit and a data-overrun bit. The host always sees the oldest unread character and its own status. One read strobe retires exactly that entry, so the host must sample the status outputs before it pops the data they belong to.

Overrun is tracked separately from the stored entries. When the queue is full, the shift register already holds another finished frame, and yet another start bit is detected, a character is about to be lost. A pending flag is then raised, and it is written into the next character that actually enters the queue. Deasserting the receiver enable empties the queue at once.

Top module: `rx_status_fifo`

## Requirements
- R1: The queue holds up to DEPTH characters (default 2) and returns them in arrival order. `rx_ready` is high exactly when at least one unread entry is present.
- R2: A push is accepted when the queue is enabled and is either not full or is being popped in the same cycle. A push into a full queue without a pop is dropped, and the stored entries stay unchanged.
- R3: A pop retires exactly one entry. From the clock edge that takes the pop, the head outputs show the next entry. A pop on an empty queue has no effect.
- R4: `head_frame_err` is 1 for an entry whose `push_stop_ok` was 0 when it was pushed, and 0 otherwise. The bit stays with that entry.
- R5: `head_parity_err` returns the `push_parity_err` value captured with the same entry.
- R6: `head_bit9` returns the `push_bit9` value captured with the same entry.
- R7: In a cycle where the queue is enabled and full and both `start_det` and `shreg_full` are 1, an overrun becomes pending. The next accepted push stores overrun = 1 in its entry and clears the pending state. Entries pushed while nothing is pending store 0.
- R8: While the queue is empty, `head_data` and all head status outputs read 0.
- R9: While `rx_enable` is 0, both entries and any pending overrun are discarded at the next edge, and push and pop are ignored. `rx_ready` is 0 after that edge.
- R10: After reset the queue is empty, `rx_ready` is 0 and no overrun is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_enable | input | 1 | Receiver enable; 0 flushes the queue |
| push_valid | input | 1 | Completed character strobe |
| push_data | input | DATA_W | Character bits |
| push_bit9 | input | 1 | Ninth data bit of the character |
| push_stop_ok | input | 1 | 1 when the first stop bit was sampled high |
| push_parity_err | input | 1 | Parity-check result from the receiver |
| start_det | input | 1 | A new start bit was detected this cycle |
| shreg_full | input | 1 | Shift register holds a finished frame not yet stored |
| rd_pop | input | 1 | Host read of the data port; retires the head |
| rx_ready | output | 1 | At least one unread entry |
| head_data | output | DATA_W | Oldest character |
| head_bit9 | output | 1 | Ninth bit of the oldest entry |
| head_frame_err | output | 1 | Frame error of the oldest entry |
| head_overrun | output | 1 | Overrun marker of the oldest entry |
| head_parity_err | output | 1 | Parity error of the oldest entry |

## Verification
The bench pushes three characters with no reads and raises an overrun while the queue is full. A design that overwrote the head or the tail would show the third character where the first or second should be. A design that attached overrun to the wrong entry would mark a character that arrived before the loss. Characters that differ in their frame-error, parity and ninth-bit values are then popped one at a time, which catches status taken from the wrong slot around a pointer advance. Simultaneous push and pop on a full queue, pops on an empty queue and flushes mid-stream are mixed into seeded random traffic. A design that mishandled any of these would lose, duplicate or resurrect a character.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   typedef struct packed {
      logic overrun;
      logic parity_err;
      logic frame_err;
      logic bit9;
   } rxq_stat_t;

   function automatic rxq_stat_t rxq_make_stat(input logic ovr, input logic perr,
                                               input logic stop_ok, input logic b9);
      rxq_stat_t s;
      s.overrun    = ovr;
      s.parity_err = perr;
      s.frame_err  = ~stop_ok;
      s.bit9       = b9;
      return s;
   endfunction

endpackage

// File: rtl/rxq_ptr.sv
module rxq_ptr #(
   parameter int DEPTH = 2,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push_req,
   input  logic             pop_req,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] rd_ptr,
   output logic [CNT_W-1:0] fill,
   output logic             push_acc,
   output logic             full
);

   logic             empty;
   logic             pop_acc;
   logic [PTR_W-1:0] wr_nxt;
   logic [PTR_W-1:0] rd_nxt;

   assign empty    = (fill == '0);
   assign full     = (fill == CNT_W'(DEPTH));
   assign pop_acc  = pop_req & ~empty & ~flush;
   assign push_acc = push_req & (~full | pop_acc) & ~flush;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + PTR_W'(1);
         assign rd_nxt = rd_ptr + PTR_W'(1);
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (push_acc) wr_ptr <= wr_nxt;
         if (pop_acc)  rd_ptr <= rd_nxt;
         fill <= fill + CNT_W'(push_acc) - CNT_W'(pop_acc);
      end
   end

endmodule

// File: rtl/rxq_ovr.sv
module rxq_ovr (
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  logic start_det,
   input  logic shreg_full,
   input  logic full,
   input  logic push_acc,
   output logic pend
);

   logic lost;

   assign lost = start_det & shreg_full & full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend <= 1'b0;
      else if (flush)    pend <= 1'b0;
      else               pend <= (push_acc ? 1'b0 : pend) | lost;
   end

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 2,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_ptr,
   input  logic [DATA_W-1:0] wr_data,
   input  rxq_pkg::rxq_stat_t wr_stat,
   input  logic [PTR_W-1:0]  rd_ptr,
   output logic [DATA_W-1:0] rd_data,
   output rxq_pkg::rxq_stat_t rd_stat
);

   logic [DATA_W-1:0]  mem_d [DEPTH];
   rxq_pkg::rxq_stat_t mem_s [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] <= '0;
            mem_s[i] <= '0;
         end
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (wr_en && (wr_ptr == PTR_W'(i))) begin
               mem_d[i] <= wr_data;
               mem_s[i] <= wr_stat;
            end
         end
      end
   end

   assign rd_data = mem_d[rd_ptr];
   assign rd_stat = mem_s[rd_ptr];

endmodule

// File: rtl/rx_status_fifo.sv
module rx_status_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_enable,
   input  logic              push_valid,
   input  logic [DATA_W-1:0] push_data,
   input  logic              push_bit9,
   input  logic              push_stop_ok,
   input  logic              push_parity_err,
   input  logic              start_det,
   input  logic              shreg_full,
   input  logic              rd_pop,
   output logic              rx_ready,
   output logic [DATA_W-1:0] head_data,
   output logic              head_bit9,
   output logic              head_frame_err,
   output logic              head_overrun,
   output logic              head_parity_err
);

   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rx_status_fifo: DEPTH must be at least 2");
      end
      if ((DATA_W < 5) || (DATA_W > 8)) begin : g_bad_width
         $error("rx_status_fifo: DATA_W must be within 5..8");
      end
   endgenerate

   logic               flush;
   logic [PTR_W-1:0]   wr_ptr;
   logic [PTR_W-1:0]   rd_ptr;
   logic [CNT_W-1:0]   fill;
   logic               push_acc;
   logic               full;
   logic               ovr_pend;
   rxq_pkg::rxq_stat_t wr_stat;
   rxq_pkg::rxq_stat_t rd_stat;
   logic [DATA_W-1:0]  rd_data;

   assign flush   = ~rx_enable;
   assign wr_stat = rxq_pkg::rxq_make_stat(ovr_pend, push_parity_err, push_stop_ok, push_bit9);

   rxq_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .push_req (push_valid),
      .pop_req  (rd_pop),
      .wr_ptr   (wr_ptr),
      .rd_ptr   (rd_ptr),
      .fill     (fill),
      .push_acc (push_acc),
      .full     (full)
   );

   rxq_ovr u_ovr (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .start_det  (start_det),
      .shreg_full (shreg_full),
      .full       (full),
      .push_acc   (push_acc),
      .pend       (ovr_pend)
   );

   rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (push_acc),
      .wr_ptr  (wr_ptr),
      .wr_data (push_data),
      .wr_stat (wr_stat),
      .rd_ptr  (rd_ptr),
      .rd_data (rd_data),
      .rd_stat (rd_stat)
   );

   assign rx_ready        = (fill != '0);
   assign head_data       = rx_ready ? rd_data : '0;
   assign head_bit9       = rx_ready & rd_stat.bit9;
   assign head_frame_err  = rx_ready & rd_stat.frame_err;
   assign head_overrun    = rx_ready & rd_stat.overrun;
   assign head_parity_err = rx_ready & rd_stat.parity_err;

endmodule

// File: rtl/rx_status_fifo_chk.sv
module rx_status_fifo_chk #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 2,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_enable,
   input logic              push_valid,
   input logic              rd_pop,
   input logic              rx_ready,
   input logic [DATA_W-1:0] head_data,
   input logic              head_bit9,
   input logic              head_frame_err,
   input logic              head_overrun,
   input logic              head_parity_err,
   input logic [CNT_W-1:0]  fill
);

   AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CNT_W'(DEPTH)); // R1

   AST_FIRST_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      rx_enable && push_valid && !rx_ready |=> rx_ready); // R2

   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      rx_enable && (fill == CNT_W'(DEPTH)) && push_valid && !rd_pop |=> (fill == CNT_W'(DEPTH))); // R2

   AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rx_enable && rx_ready && !rd_pop |=> rx_ready && $stable(head_data) && $stable(head_bit9)
         && $stable(head_frame_err) && $stable(head_parity_err) && $stable(head_overrun)); // R3

   AST_LAST_POP: assert property (@(posedge clk) disable iff (!rst_n)
      rx_enable && (fill == CNT_W'(1)) && rd_pop && !push_valid |=> !rx_ready); // R3

   AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_ready |-> (head_data == '0) && !head_bit9 && !head_frame_err
         && !head_overrun && !head_parity_err); // R8

   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_enable |=> !rx_ready); // R9

endmodule

bind rx_status_fifo rx_status_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .rx_enable       (rx_enable),
   .push_valid      (push_valid),
   .rd_pop          (rd_pop),
   .rx_ready        (rx_ready),
   .head_data       (head_data),
   .head_bit9       (head_bit9),
   .head_frame_err  (head_frame_err),
   .head_overrun    (head_overrun),
   .head_parity_err (head_parity_err),
   .fill            (fill)
);

// File: tb/tb_rx_status_fifo.sv
module tb_rx_status_fifo;

   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_enable = 1'b1;
   logic          push_valid = 1'b0;
   logic [DW-1:0] push_data = '0;
   logic          push_bit9 = 1'b0;
   logic          push_stop_ok = 1'b1;
   logic          push_parity_err = 1'b0;
   logic          start_det = 1'b0;
   logic          shreg_full = 1'b0;
   logic          rd_pop = 1'b0;
   logic          rx_ready;
   logic [DW-1:0] head_data;
   logic          head_bit9, head_frame_err, head_overrun, head_parity_err;

   int nchk = 0;
   int nfail = 0;

   // model entry: {overrun, parity_err, frame_err, bit9, data}
   logic [DW+3:0] mq[$];
   logic          m_pend = 1'b0;

   always #10 clk = ~clk;

   rx_status_fifo #(.DATA_W(DW), .DEPTH(2)) dut (
      .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .push_valid(push_valid),
      .push_data(push_data), .push_bit9(push_bit9), .push_stop_ok(push_stop_ok),
      .push_parity_err(push_parity_err), .start_det(start_det), .shreg_full(shreg_full),
      .rd_pop(rd_pop), .rx_ready(rx_ready), .head_data(head_data), .head_bit9(head_bit9),
      .head_frame_err(head_frame_err), .head_overrun(head_overrun),
      .head_parity_err(head_parity_err)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic void model_edge();
      logic lost, pop_ok, push_ok;
      if (!rx_enable) begin
         mq.delete();
         m_pend = 1'b0;
      end else begin
         lost    = start_det && shreg_full && (mq.size() == 2);
         pop_ok  = rd_pop && (mq.size() > 0);
         push_ok = push_valid && ((mq.size() < 2) || pop_ok);
         if (pop_ok) void'(mq.pop_front());
         if (push_ok) mq.push_back({m_pend, push_parity_err, ~push_stop_ok, push_bit9, push_data});
         m_pend = (push_ok ? 1'b0 : m_pend) | lost;
      end
   endfunction

   task automatic compare_all();
      logic [DW+3:0] e;
      bit emp;
      emp = (mq.size() == 0);
      e = emp ? '0 : mq[0];
      chk("R1 rx_ready", 32'(rx_ready), 32'(!emp));
      chk(emp ? "R8 data" : "R3 data", 32'(head_data), 32'(e[DW-1:0]));
      chk(emp ? "R8 bit9" : "R6 bit9", 32'(head_bit9), 32'(e[DW]));
      chk(emp ? "R8 frame" : "R4 frame", 32'(head_frame_err), 32'(e[DW+1]));
      chk(emp ? "R8 parity" : "R5 parity", 32'(head_parity_err), 32'(e[DW+2]));
      chk(emp ? "R8 ovr" : "R7 ovr", 32'(head_overrun), 32'(e[DW+3]));
   endtask

   task automatic step(input bit en, input bit psh, input logic [DW-1:0] d, input bit b9,
                       input bit stp, input bit pe, input bit st, input bit sf, input bit pop);
      rx_enable = en; push_valid = psh; push_data = d; push_bit9 = b9;
      push_stop_ok = stp; push_parity_err = pe; start_det = st; shreg_full = sf; rd_pop = pop;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare_all();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0a17));
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10 ready", 32'(rx_ready), 32'd0);
      chk("R10 data", 32'(head_data), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      compare_all();

      // three frames without reads, overrun while full
      step(1, 1, 8'h11, 1, 1, 0, 0, 0, 0);   // A
      step(1, 1, 8'h22, 0, 0, 1, 0, 0, 0);   // B: frame err + parity err
      step(1, 0, 8'h00, 0, 1, 0, 1, 1, 0);   // overrun condition R7
      step(1, 1, 8'h33, 1, 1, 1, 0, 0, 0);   // C dropped, R2
      chk("R2 head still first", 32'(head_data), 32'h11);
      chk("R6 first bit9", 32'(head_bit9), 32'd1);
      chk("R7 first no ovr", 32'(head_overrun), 32'd0);
      step(1, 0, 8'h00, 0, 1, 0, 0, 0, 1);   // pop A
      chk("R4 second frame err", 32'(head_frame_err), 32'd1);
      chk("R7 second no ovr", 32'(head_overrun), 32'd0);
      step(1, 1, 8'h44, 0, 1, 0, 0, 0, 0);   // D gets overrun
      step(1, 0, 8'h00, 0, 1, 0, 0, 0, 1);   // pop B
      chk("R7 ovr on next entry", 32'(head_overrun), 32'd1);
      chk("R3 next data", 32'(head_data), 32'h44);
      step(1, 0, 8'h00, 0, 1, 0, 0, 0, 1);   // pop D
      step(1, 0, 8'h00, 0, 1, 0, 0, 0, 1);   // pop on empty R3
      chk("R3 empty pop", 32'(rx_ready), 32'd0);
      // full with simultaneous push and pop
      step(1, 1, 8'h55, 0, 1, 0, 0, 0, 0);
      step(1, 1, 8'h66, 1, 1, 0, 0, 0, 0);
      step(1, 1, 8'h77, 0, 0, 1, 0, 0, 1);
      chk("R2 push with pop when full", 32'(head_data), 32'h66);
      // flush R9
      step(0, 1, 8'h88, 0, 1, 0, 1, 1, 1);
      chk("R9 flushed", 32'(rx_ready), 32'd0);
      step(1, 1, 8'h99, 0, 1, 0, 0, 0, 0);
      chk("R9 no stale ovr", 32'(head_overrun), 32'd0);

      // seeded random traffic
      for (int i = 0; i < 4000; i++) begin
         step(($urandom % 40) != 0, ($urandom % 2) == 0, DW'($urandom), ($urandom % 2) == 0,
              ($urandom % 7) != 0, ($urandom % 5) == 0, ($urandom % 4) == 0,
              ($urandom % 2) == 0, ($urandom % 5) < 2);
      end

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

endmodule